// File: doc/BRIEF.md
# Daisy-Chained Acknowledge Chain for One Interrupt Level

This block holds the interrupt logic of every device that shares a single priority level. Each device keeps one request flip-flop. A set flip-flop pulls a shared, active-low request line to 0. The line is modelled as the AND of all device drives, so any number of devices can request at once without conflict. The level arbiter sees only that one line.

When the arbiter grants the level, it raises the acknowledge input. The acknowledge enters at device 0, the device nearest the CPU, and ripples down the chain. A device with no pending request hands it on unchanged. The first device with a pending request keeps it and does not forward it. That device places its vector on the vector bus for that cycle and clears its flip-flop at the clock edge that ends the cycle. Priority within the level therefore follows chain position alone. Every clock cycle in which the acknowledge input is high counts as one acknowledge cycle.

Each device is a two-state machine:
- `DEV_IDLE` means no request is held. It drives the line high and passes the acknowledge on.
- `DEV_PEND` means a request is held. It pulls the line low, blocks the acknowledge, and asserts its grant when the acknowledge arrives.

The transitions are:
- *raise*: `DEV_IDLE` → `DEV_PEND` on a raise pulse.
- *serve*: `DEV_PEND` → `DEV_IDLE` when the acknowledge arrives and no raise is present in the same cycle.
- *re-raise*: `DEV_PEND` stays in `DEV_PEND` when the acknowledge and a raise arrive together.
- *hold*: every other case keeps the current state.

Top module: `irqc_daisy_chain`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, every bit of `pending_o` is 0, `req_n_o` is 1, `vec_valid_o` is 0 and `vec_o` is 0.
- R2: A high `raise_i[i]` at a clock edge sets `pending_o[i]` to 1 from that edge on. Bit i of `raise_i` and of `pending_o` belongs to device i, and device 0 is nearest the CPU.
- R3: `req_n_o` is 0 whenever one or more bits of `pending_o` are 1, including when several are 1. It is 1 when none is set.
- R4: In a cycle with `ack_i` high, only the lowest-numbered device with a pending request is granted. `vec_valid_o` is then 1 and `vec_o` equals `VEC_BASE + i*VEC_STRIDE` for that device i. With the defaults these vectors are 0x40, 0x44, 0x48 and 0x4C.
- R5: `ack_tail_o` follows `ack_i` when no device is pending and is 0 whenever any device is pending.
- R6: At the edge that ends an acknowledge cycle, the granted device's pending bit clears. Every other device's pending bit is unchanged.
- R7: A raise that arrives in the same cycle as an acknowledge is not served by that acknowledge. The device becomes pending and waits for the next acknowledge.
- R8: If the granted device is also raised in its acknowledge cycle, its pending bit stays at 1.
- R9: With `ack_i` low, `vec_valid_o` is 0, `vec_o` is 0, `ack_tail_o` is 0, and no pending bit clears.
- R10: With `ack_i` held high over consecutive cycles, one device is served per cycle, in order of increasing index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | N_DEV | Per-device request pulse, bit i is device i |
| ack_i | input | 1 | Acknowledge from the level arbiter, high for each acknowledge cycle |
| req_n_o | output | 1 | Shared active-low request line (AND of device drives) |
| ack_tail_o | output | 1 | Acknowledge leaving the last device of the chain |
| vec_valid_o | output | 1 | A device holds the acknowledge in this cycle |
| vec_o | output | VEC_W | Vector of the granted device, 0 when none |
| pending_o | output | N_DEV | Request flip-flop of each device |

## Verification
The assertions take `raise_i` and `ack_i` as synchronous, settled levels sampled at the rising edge. They also assume the arbiter drives `ack_i` without regard to `req_n_o`, so an acknowledge may arrive with nobody pending. The stimulus changes both inputs only on falling edges and reads the outputs just before the next rising edge. Every combination the checks depend on therefore lies within one settled cycle. The sequence deliberately includes an acknowledge into an empty chain, a raise that collides with an acknowledge, and acknowledges held over several cycles, so the pass-through, late-raise and back-to-back serve cases all occur.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Per-device request state.
    typedef enum logic [0:0] {
        DEV_IDLE = 1'b0,
        DEV_PEND = 1'b1
    } irqc_state_e;

    // Vector assigned to the device at chain position idx.
    function automatic int unsigned vec_of(input int unsigned base,
                                           input int unsigned stride,
                                           input int unsigned idx);
        return base + idx * stride;
    endfunction

endpackage

// File: rtl/irqc_device.sv
module irqc_device
    import irqc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise_i,
    input  logic ack_up_i,
    output logic ack_down_o,
    output logic req_drive_n_o,
    output logic grant_o,
    output logic pending_o
);

    irqc_state_e state_q;
    irqc_state_e state_d;

    // Next-state logic: raise / serve / re-raise / hold.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DEV_IDLE: begin
                if (raise_i) begin
                    state_d = DEV_PEND;
                end
            end
            DEV_PEND: begin
                if (ack_up_i && !raise_i) begin
                    state_d = DEV_IDLE;
                end
            end
            default: state_d = DEV_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs from the current state and the incoming acknowledge.
    always_comb begin
        ack_down_o    = 1'b0;
        req_drive_n_o = 1'b1;
        grant_o       = 1'b0;
        pending_o     = 1'b0;
        unique case (state_q)
            DEV_IDLE: begin
                ack_down_o = ack_up_i;
            end
            DEV_PEND: begin
                req_drive_n_o = 1'b0;
                grant_o       = ack_up_i;
                pending_o     = 1'b1;
            end
            default: begin
                ack_down_o = 1'b0;
            end
        endcase
    end

    // R2: a raise always leaves the device pending after the edge.
    assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        raise_i |=> pending_o);

    // R6: a served device without a new raise is idle after the edge.
    assert_serve_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o && !raise_i) |=> !pending_o);

    // R9: with no acknowledge arriving, a pending request stays pending.
    assert_hold_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !ack_up_i) |=> pending_o);

    // R5: a pending device never lets the acknowledge through.
    assert_block_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o |-> !ack_down_o);

endmodule

// File: rtl/irqc_vec_sel.sv
module irqc_vec_sel
    import irqc_pkg::*;
#(
    parameter int unsigned N_DEV      = 4,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 64,
    parameter int unsigned VEC_STRIDE = 4
) (
    input  logic [N_DEV-1:0] grant_i,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o
);

    // Grants are one-hot, so an OR of the gated vectors selects the winner.
    always_comb begin
        vec_o = '0;
        for (int i = 0; i < int'(N_DEV); i++) begin
            if (grant_i[i]) begin
                vec_o = vec_o | VEC_W'(vec_of(VEC_BASE, VEC_STRIDE, i));
            end
        end
        vec_valid_o = |grant_i;
    end

endmodule

// File: rtl/irqc_daisy_chain.sv
module irqc_daisy_chain
    import irqc_pkg::*;
#(
    parameter int unsigned N_DEV      = 4,
    parameter int unsigned VEC_W      = 8,
    parameter int unsigned VEC_BASE   = 64,
    parameter int unsigned VEC_STRIDE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DEV-1:0] raise_i,
    input  logic             ack_i,
    output logic             req_n_o,
    output logic             ack_tail_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N_DEV-1:0] pending_o
);

    logic [N_DEV:0]   ack_chain;
    logic [N_DEV-1:0] drive_n;
    logic [N_DEV-1:0] grant;

    assign ack_chain[0] = ack_i;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        irqc_device u_dev (
            .clk           (clk),
            .rst_n         (rst_n),
            .raise_i       (raise_i[g]),
            .ack_up_i      (ack_chain[g]),
            .ack_down_o    (ack_chain[g+1]),
            .req_drive_n_o (drive_n[g]),
            .grant_o       (grant[g]),
            .pending_o     (pending_o[g])
        );

        if (g > 0) begin : g_rank
            localparam logic [N_DEV-1:0] LOWER = N_DEV'((1 << g) - 1);

            // R4: a device is granted only when no nearer device is pending.
            assert_nearest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                grant[g] |-> ((pending_o & LOWER) == '0));
        end
    end

    // Wired-AND request line.
    assign req_n_o    = &drive_n;
    assign ack_tail_o = ack_chain[N_DEV];

    irqc_vec_sel #(
        .N_DEV      (N_DEV),
        .VEC_W      (VEC_W),
        .VEC_BASE   (VEC_BASE),
        .VEC_STRIDE (VEC_STRIDE)
    ) u_vec (
        .grant_i     (grant),
        .vec_valid_o (vec_valid_o),
        .vec_o       (vec_o)
    );

    // R4: at most one device holds the acknowledge.
    assert_single_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: several simultaneous requesters still leave the line low.
    assert_shared_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pending_o) > 1) |-> !req_n_o);

    // R5: an empty chain passes the acknowledge to the tail.
    assert_empty_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pending_o == '0) |-> ack_tail_o);

    // R5: any pending device stops the acknowledge before the tail.
    assert_tail_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o != '0) |-> !ack_tail_o);

    // R9: no vector and no tail acknowledge outside an acknowledge cycle.
    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_i |-> (!vec_valid_o && vec_o == '0 && !ack_tail_o));

    // R4: a pending chain under acknowledge always presents a vector.
    assert_vector_given_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pending_o != '0) |-> vec_valid_o);

endmodule

// File: tb/tb_irqc_daisy_chain.sv
module tb_irqc_daisy_chain;

    localparam int N = 4;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  raise_i = '0;
    logic          ack_i = 1'b0;
    logic          req_n_o;
    logic          ack_tail_o;
    logic          vec_valid_o;
    logic [VW-1:0] vec_o;
    logic [N-1:0]  pending_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    irqc_daisy_chain #(.N_DEV(N), .VEC_W(VW), .VEC_BASE(64), .VEC_STRIDE(4)) dut (
        .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .ack_i(ack_i),
        .req_n_o(req_n_o), .ack_tail_o(ack_tail_o), .vec_valid_o(vec_valid_o),
        .vec_o(vec_o), .pending_o(pending_o)
    );

    typedef struct packed {
        logic [N-1:0]  raise;
        logic          ack;
        logic [N-1:0]  exp_pend;   // state before this row's edge
        logic          exp_valid;
        logic [VW-1:0] exp_vec;
        logic          exp_tail;
    } row_t;

    localparam int ROWS = 19;
    localparam row_t TABLE [ROWS] = '{
        '{4'b0000, 1'b0, 4'b0000, 1'b0, 8'h00, 1'b0},  // R1 idle after reset
        '{4'b0000, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b1},  // R5 empty pass-through
        '{4'b0100, 1'b0, 4'b0000, 1'b0, 8'h00, 1'b0},  // R2 raise dev2
        '{4'b1001, 1'b0, 4'b0100, 1'b0, 8'h00, 1'b0},  // R2 raise dev0, dev3
        '{4'b0000, 1'b1, 4'b1101, 1'b1, 8'h40, 1'b0},  // R4 dev0 wins
        '{4'b0000, 1'b0, 4'b1100, 1'b0, 8'h00, 1'b0},  // R6 R9 only dev0 cleared
        '{4'b0000, 1'b1, 4'b1100, 1'b1, 8'h48, 1'b0},  // R4 dev2
        '{4'b0001, 1'b1, 4'b1000, 1'b1, 8'h4C, 1'b0},  // R7 late raise dev0, dev3 served
        '{4'b0000, 1'b0, 4'b0001, 1'b0, 8'h00, 1'b0},  // R7 dev0 now pending
        '{4'b0001, 1'b1, 4'b0001, 1'b1, 8'h40, 1'b0},  // R8 re-raise while served
        '{4'b0000, 1'b0, 4'b0001, 1'b0, 8'h00, 1'b0},  // R8 still pending
        '{4'b0000, 1'b1, 4'b0001, 1'b1, 8'h40, 1'b0},  // R6 serve dev0
        '{4'b1111, 1'b0, 4'b0000, 1'b0, 8'h00, 1'b0},  // R2 all raise
        '{4'b0000, 1'b1, 4'b1111, 1'b1, 8'h40, 1'b0},  // R10 burst 1
        '{4'b0000, 1'b1, 4'b1110, 1'b1, 8'h44, 1'b0},  // R10 burst 2
        '{4'b0000, 1'b1, 4'b1100, 1'b1, 8'h48, 1'b0},  // R10 burst 3
        '{4'b0000, 1'b1, 4'b1000, 1'b1, 8'h4C, 1'b0},  // R10 burst 4
        '{4'b0000, 1'b1, 4'b0000, 1'b0, 8'h00, 1'b1},  // R5 drained chain
        '{4'b0000, 1'b0, 4'b0000, 1'b0, 8'h00, 1'b0}   // R9 quiet
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: outputs during reset
        #15;
        check("R1 pending in reset", 32'(pending_o), 32'h0);
        check("R1 req_n in reset", 32'(req_n_o), 32'h1);
        check("R1 vec_valid in reset", 32'(vec_valid_o), 32'h0);
        check("R1 vec in reset", 32'(vec_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int r = 0; r < ROWS; r++) begin
            raise_i = TABLE[r].raise;
            ack_i   = TABLE[r].ack;
            #5;  // settle, well before the next rising edge
            check("R2 pending", 32'(pending_o), 32'(TABLE[r].exp_pend));
            check("R3 req_n", 32'(req_n_o), 32'(TABLE[r].exp_pend == '0));
            check("R4 vec_valid", 32'(vec_valid_o), 32'(TABLE[r].exp_valid));
            check("R4 vec", 32'(vec_o), 32'(TABLE[r].exp_vec));
            check("R5 ack_tail", 32'(ack_tail_o), 32'(TABLE[r].exp_tail));
            @(negedge clk);
        end

        // R1: reset in mid-run clears held requests
        raise_i = 4'b0110;
        ack_i   = 1'b0;
        @(negedge clk);
        raise_i = '0;
        #2;
        check("R3 two requesters", 32'(req_n_o), 32'h0);
        rst_n = 1'b0;
        #2;
        check("R1 pending cleared", 32'(pending_o), 32'h0);
        check("R1 req_n released", 32'(req_n_o), 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: the late raiser is not served by the current acknowledge
        raise_i = 4'b0010;
        ack_i   = 1'b1;
        #5;
        check("R7 late raise not granted", 32'(vec_valid_o), 32'h0);
        check("R7 tail passes", 32'(ack_tail_o), 32'h1);
        @(negedge clk);
        raise_i = '0;
        #5;
        check("R7 served next acknowledge", 32'(vec_o), 32'h44);
        @(negedge clk);
        ack_i = 1'b0;
        #5;
        check("R6 cleared after serve", 32'(pending_o), 32'h0);

        finish_run();
    end

endmodule